// File: doc/BRIEF.md
# Calendar Time Counter with BCD/Binary Encoding

This block keeps wall-clock time and date: seconds, minutes, hours, day of the week, day of the month, month and a two-digit year. A one-second tick moves it forward. The tick is accepted only when a three-bit oscillator control field holds the running pattern. The block holds the current time in binary. Each field is presented as an output byte in packed BCD or in plain binary, and the hour can be shown in 24-hour or 12-hour form.

Each accepted tick advances the internal counter and opens a short update window. While the window is open, the update-in-progress flag is high. At the end of the window the output bytes are rewritten from the counter, the flag drops, and an update-ended strobe is pulsed for one cycle.

A host can overwrite any time byte. While the set flag is high, the output bytes are frozen apart from host writes, and the counter is not copied into them. The counter takes its value from the bytes after a host write made with the set flag low, or after the set flag falls.

Top module: `rtc_calendar_core`

## Requirements
- R1: A tick is accepted only when `osc_ctl` equals 3'b010. With any other value, a pulse on `sec_tick` opens no window, leaves `uip` low and changes no byte.
- R2: While `set_mode` is high, the time bytes change only through host writes. One cycle after a host write made with `set_mode` low, or one cycle after `set_mode` falls, the counter reloads from all seven bytes. Any advance the counter made while `set_mode` was high is discarded.
- R3: On the clock edge that accepts a tick, `uip` rises, unless `set_mode` is high. `uip` stays high for WIN_CYCLES cycles, default 8. On the next edge it falls, the time bytes take their new values, and `upd_end` is high for exactly one cycle. The window runs and `upd_end` still pulses when `set_mode` is high.
- R4: When `bin_mode` is high, every field is plain binary. Otherwise every field is packed BCD: tens digit in bits 7:4 and units digit in bits 3:0.
- R5: When `hr24_mode` is high, the hour byte holds 0 to 23. When it is low, bits 6:0 hold the hour in 1 to 12 form, with hour 0 shown as 12, and bit 7 is set for hours 12 to 23. Hour bytes written by the host are read back the same way.
- R6: Seconds wrap from 59 to 0 into minutes, and minutes wrap from 59 to 0 into hours. Hours wrap from 23 to 0, which advances both day of week and day of month. Day of week runs 1 to 7 and wraps from 7 to 1.
- R7: Month lengths are 31, 28, 31, 30, 31, 30, 31, 31, 30, 31, 30, 31. February has 29 days in a leap year. The full year is CENTURY×100 plus the two-digit year, with CENTURY defaulting to 20, so year 00 is the leap year 2000.
- R8: The end of the last day of month 12 gives month 1, day 1. The two-digit year wraps from 99 to 00.
- R9: A tick that arrives while an update window is open is ignored.
- R10: After reset the bytes are, from seconds through year, 00 00 00 01 01 01 00, and `uip` and `upd_end` are low. Host writes select a byte with `ld_sel`: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month, 6 year. A write with `ld_sel` = 7 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| osc_ctl | input | 3 | Oscillator control field; 3'b010 enables counting |
| set_mode | input | 1 | Freezes the bytes against updates from the counter |
| bin_mode | input | 1 | 1 = binary fields, 0 = packed BCD |
| hr24_mode | input | 1 | 1 = 24-hour, 0 = 12-hour with PM in bit 7 |
| ld_en | input | 1 | Host byte write strobe |
| ld_sel | input | 3 | Host byte select (0 to 6) |
| ld_data | input | 8 | Host byte value, in the current encoding |
| t_sec | output | 8 | Seconds byte |
| t_min | output | 8 | Minutes byte |
| t_hour | output | 8 | Hours byte |
| t_wday | output | 8 | Day-of-week byte |
| t_mday | output | 8 | Day-of-month byte |
| t_mon | output | 8 | Month byte |
| t_year | output | 8 | Two-digit year byte |
| uip | output | 1 | Update in progress |
| upd_end | output | 1 | One-cycle update-ended strobe |

## Verification
The calendar carries are the hardest to reach from the ports, because reaching the end of a month or a year by ticking would take millions of seconds. The bench avoids this by raising `set_mode` and writing all seven bytes a second before the boundary. It then drops `set_mode` so the counter reloads from those bytes, and gives one tick. The same approach covers the leap-year Februaries, the 12-hour noon and midnight crossings, and the case where an advance made during set mode is thrown away.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int unsigned NUM_BYTES = 7;

  typedef struct packed {
    logic [6:0] year;
    logic [3:0] mon;
    logic [4:0] mday;
    logic [2:0] wday;
    logic [4:0] hour;
    logic [5:0] min;
    logic [5:0] sec;
  } cal_t;

  // index 0 seconds ... 6 year
  typedef logic [NUM_BYTES-1:0][7:0] tbytes_t;

  function automatic logic [7:0] to_bcd(input logic [6:0] v);
    logic [6:0] t, u;
    t = v / 7'd10;
    u = v - t * 7'd10;
    return {t[3:0], u[3:0]};
  endfunction

  function automatic logic [6:0] from_bcd(input logic [7:0] b);
    return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
  endfunction

  function automatic logic [7:0] enc(input logic [6:0] v, input logic bin);
    return bin ? {1'b0, v} : to_bcd(v);
  endfunction

  function automatic logic [6:0] dec(input logic [7:0] b, input logic bin);
    return bin ? b[6:0] : from_bcd(b);
  endfunction

  function automatic cal_t cal_from_bytes(input tbytes_t b, input logic bin,
                                          input logic h24);
    cal_t c;
    logic [6:0] v;
    logic [6:0] hr;
    v = dec(b[0], bin); c.sec  = v[5:0];
    v = dec(b[1], bin); c.min  = v[5:0];
    v = dec(b[3], bin); c.wday = v[2:0];
    v = dec(b[4], bin); c.mday = v[4:0];
    v = dec(b[5], bin); c.mon  = v[3:0];
    c.year = dec(b[6], bin);
    hr = dec({1'b0, b[2][6:0]}, bin);
    if (!h24) begin
      if (hr == 7'd12) hr = 7'd0;
      if (b[2][7]) hr = hr + 7'd12;
    end
    c.hour = hr[4:0];
    return c;
  endfunction

endpackage

// File: rtl/rtc_cal_window.sv
module rtc_cal_window #(
  parameter int unsigned WIN_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic set_mode,
  output logic busy,
  output logic win_end,
  output logic uip
);
  localparam int unsigned CW = $clog2(WIN_CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          uip_q, uip_d;

  assign busy    = (cnt_q != '0);
  assign win_end = (cnt_q == CW'(1));
  assign uip     = uip_q;

  always_comb begin
    cnt_d = cnt_q;
    if (start)     cnt_d = CW'(WIN_CYCLES);
    else if (busy) cnt_d = cnt_q - CW'(1);
  end

  always_comb begin
    uip_d = uip_q;
    if (set_mode)     uip_d = 1'b0;
    else if (start)   uip_d = 1'b1;
    else if (win_end) uip_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      uip_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      uip_q <= uip_d;
    end
  end

  AST_UIP_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    uip_q |-> busy); // R3

endmodule

// File: rtl/rtc_cal_counter.sv
module rtc_cal_counter
  import rtc_cal_pkg::*;
#(
  parameter int unsigned CENTURY = 20
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    adv,
  input  logic    resync,
  input  logic    bin_mode,
  input  logic    hr24_mode,
  input  tbytes_t bytes_in,
  output cal_t    cal
);
  localparam logic CENT_LEAP = ((CENTURY % 4) == 0);

  cal_t       cal_q, cal_d, nxt;
  logic       leap;
  logic [4:0] dim;

  assign leap = (cal_q.year[1:0] == 2'd0) && ((cal_q.year != 7'd0) || CENT_LEAP);

  always_comb begin
    case (cal_q.mon)
      4'd2:                       dim = leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:    dim = 5'd30;
      default:                    dim = 5'd31;
    endcase
  end

  always_comb begin
    nxt = cal_q;
    if (cal_q.sec < 6'd59) nxt.sec = cal_q.sec + 6'd1;
    else begin
      nxt.sec = '0;
      if (cal_q.min < 6'd59) nxt.min = cal_q.min + 6'd1;
      else begin
        nxt.min = '0;
        if (cal_q.hour < 5'd23) nxt.hour = cal_q.hour + 5'd1;
        else begin
          nxt.hour = '0;
          nxt.wday = (cal_q.wday >= 3'd7) ? 3'd1 : cal_q.wday + 3'd1;
          if (cal_q.mday < dim) nxt.mday = cal_q.mday + 5'd1;
          else begin
            nxt.mday = 5'd1;
            if (cal_q.mon < 4'd12) nxt.mon = cal_q.mon + 4'd1;
            else begin
              nxt.mon  = 4'd1;
              nxt.year = (cal_q.year >= 7'd99) ? 7'd0 : cal_q.year + 7'd1;
            end
          end
        end
      end
    end
  end

  always_comb begin
    cal_d = cal_q;
    if (resync)   cal_d = cal_from_bytes(bytes_in, bin_mode, hr24_mode);
    else if (adv) cal_d = nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_q <= '{year: 7'd0, mon: 4'd1, mday: 5'd1, wday: 3'd1,
                 hour: 5'd0, min: 6'd0, sec: 6'd0};
    end else begin
      cal_q <= cal_d;
    end
  end

  assign cal = cal_q;

  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !resync && cal_q.sec == 6'd59) |=> (cal_q.sec == 6'd0)); // R6

endmodule

// File: rtl/rtc_cal_encode.sv
module rtc_cal_encode
  import rtc_cal_pkg::*;
(
  input  cal_t    cal,
  input  logic    bin_mode,
  input  logic    hr24_mode,
  output tbytes_t bytes_out
);
  logic [4:0] h12;
  logic       pm;

  assign pm  = (cal.hour >= 5'd12);

  always_comb begin
    h12 = pm ? cal.hour - 5'd12 : cal.hour;
    if (h12 == 5'd0) h12 = 5'd12;
  end

  always_comb begin
    bytes_out[0] = enc(7'(cal.sec), bin_mode);
    bytes_out[1] = enc(7'(cal.min), bin_mode);
    bytes_out[2] = hr24_mode ? enc(7'(cal.hour), bin_mode)
                             : (enc(7'(h12), bin_mode) | {pm, 7'd0});
    bytes_out[3] = enc(7'(cal.wday), bin_mode);
    bytes_out[4] = enc(7'(cal.mday), bin_mode);
    bytes_out[5] = enc(7'(cal.mon), bin_mode);
    bytes_out[6] = enc(cal.year, bin_mode);
  end

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_cal_pkg::*;
#(
  parameter int unsigned CENTURY    = 20,
  parameter int unsigned WIN_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick,
  input  logic [2:0] osc_ctl,
  input  logic       set_mode,
  input  logic       bin_mode,
  input  logic       hr24_mode,
  input  logic       ld_en,
  input  logic [2:0] ld_sel,
  input  logic [7:0] ld_data,
  output logic [7:0] t_sec,
  output logic [7:0] t_min,
  output logic [7:0] t_hour,
  output logic [7:0] t_wday,
  output logic [7:0] t_mday,
  output logic [7:0] t_mon,
  output logic [7:0] t_year,
  output logic       uip,
  output logic       upd_end
);
  localparam logic [2:0] OSC_RUN   = 3'b010;
  localparam tbytes_t    RST_BYTES = {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

  logic    busy, win_end, start, wb;
  logic    set_q, resync_q, resync_d, upd_end_q;
  logic    ld_valid;
  cal_t    cal;
  tbytes_t enc_bytes, bytes_pk;
  logic [7:0] byte_q [NUM_BYTES];
  logic [7:0] byte_d [NUM_BYTES];

  assign start    = sec_tick && (osc_ctl == OSC_RUN) && !busy;
  assign wb       = win_end && !set_mode;
  assign ld_valid = ld_en && (ld_sel < 3'(NUM_BYTES));
  assign resync_d = (ld_valid && !set_mode) || (set_q && !set_mode);

  rtc_cal_window #(.WIN_CYCLES(WIN_CYCLES)) u_window (
    .clk(clk), .rst_n(rst_n), .start(start), .set_mode(set_mode),
    .busy(busy), .win_end(win_end), .uip(uip)
  );

  rtc_cal_counter #(.CENTURY(CENTURY)) u_counter (
    .clk(clk), .rst_n(rst_n), .adv(start), .resync(resync_q),
    .bin_mode(bin_mode), .hr24_mode(hr24_mode),
    .bytes_in(bytes_pk), .cal(cal)
  );

  rtc_cal_encode u_encode (
    .cal(cal), .bin_mode(bin_mode), .hr24_mode(hr24_mode),
    .bytes_out(enc_bytes)
  );

  for (genvar gi = 0; gi < NUM_BYTES; gi++) begin : g_byte
    logic hit;
    assign hit = ld_en && (ld_sel == 3'(gi));

    always_comb begin
      byte_d[gi] = byte_q[gi];
      if (wb)  byte_d[gi] = enc_bytes[gi];
      if (hit) byte_d[gi] = ld_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) byte_q[gi] <= RST_BYTES[gi];
      else        byte_q[gi] <= byte_d[gi];
    end

    assign bytes_pk[gi] = byte_q[gi];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_q     <= 1'b0;
      resync_q  <= 1'b0;
      upd_end_q <= 1'b0;
    end else begin
      set_q     <= set_mode;
      resync_q  <= resync_d;
      upd_end_q <= win_end;
    end
  end

  assign t_sec   = byte_q[0];
  assign t_min   = byte_q[1];
  assign t_hour  = byte_q[2];
  assign t_wday  = byte_q[3];
  assign t_mday  = byte_q[4];
  assign t_mon   = byte_q[5];
  assign t_year  = byte_q[6];
  assign upd_end = upd_end_q;

  AST_TICK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uip) |-> $past(sec_tick && osc_ctl == OSC_RUN)); // R1
  AST_SET_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mode && !ld_en) |=> $stable({t_sec, t_min, t_hour, t_wday, t_mday, t_mon, t_year})); // R2
  AST_END_DROPS_UIP: assert property (@(posedge clk) disable iff (!rst_n)
    upd_end |-> !uip); // R3

endmodule

// File: tb/rtc_calendar_core_test.sv
module rtc_calendar_core_test;
  localparam int CLK_PERIOD = 10;
  localparam int WIN = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic sec_tick, set_mode, bin_mode, hr24_mode, ld_en;
  logic [2:0] osc_ctl, ld_sel;
  logic [7:0] ld_data;
  logic [7:0] t_sec, t_min, t_hour, t_wday, t_mday, t_mon, t_year;
  logic uip, upd_end;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_calendar_core #(.CENTURY(20), .WIN_CYCLES(WIN)) uut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .osc_ctl(osc_ctl),
    .set_mode(set_mode), .bin_mode(bin_mode), .hr24_mode(hr24_mode),
    .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
    .t_sec(t_sec), .t_min(t_min), .t_hour(t_hour), .t_wday(t_wday),
    .t_mday(t_mday), .t_mon(t_mon), .t_year(t_year),
    .uip(uip), .upd_end(upd_end)
  );

  task automatic chk(string req, string what, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %02h expected %02h", req, what, got, exp);
    end
  endtask

  task automatic expect_time(string req, logic [7:0] s, logic [7:0] m, logic [7:0] h,
                             logic [7:0] w, logic [7:0] d, logic [7:0] mo, logic [7:0] y);
    chk(req, "sec", t_sec, s);   chk(req, "min", t_min, m);
    chk(req, "hour", t_hour, h); chk(req, "wday", t_wday, w);
    chk(req, "mday", t_mday, d); chk(req, "mon", t_mon, mo);
    chk(req, "year", t_year, y);
  endtask

  task automatic write_byte(logic [2:0] sel, logic [7:0] val);
    @(negedge clk); ld_en = 1'b1; ld_sel = sel; ld_data = val;
    @(negedge clk); ld_en = 1'b0;
  endtask

  task automatic load_time(logic [7:0] s, logic [7:0] m, logic [7:0] h,
                           logic [7:0] w, logic [7:0] d, logic [7:0] mo, logic [7:0] y);
    @(negedge clk); set_mode = 1'b1;
    write_byte(3'd0, s); write_byte(3'd1, m); write_byte(3'd2, h);
    write_byte(3'd3, w); write_byte(3'd4, d); write_byte(3'd5, mo);
    write_byte(3'd6, y);
    @(negedge clk); set_mode = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // leaves the bench just after the edge where the window closes
  task automatic tick_full();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
    repeat (WIN) @(negedge clk);
  endtask

  task automatic t_reset();
    expect_time("R10", 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    chk("R10", "uip", 8'(uip), 8'h00);
    chk("R10", "upd_end", 8'(upd_end), 8'h00);
  endtask

  task automatic t_basic();
    load_time(8'h56, 8'h34, 8'h12, 8'h03, 8'h15, 8'h06, 8'h24);
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
    chk("R3", "uip after accept", 8'(uip), 8'h01);
    chk("R3", "bytes before window end", t_sec, 8'h56);
    repeat (WIN - 1) @(negedge clk);
    chk("R3", "uip last window cycle", 8'(uip), 8'h01);
    chk("R3", "upd_end early", 8'(upd_end), 8'h00);
    @(negedge clk);
    chk("R3", "uip cleared", 8'(uip), 8'h00);
    chk("R3", "upd_end pulse", 8'(upd_end), 8'h01);
    expect_time("R4", 8'h57, 8'h34, 8'h12, 8'h03, 8'h15, 8'h06, 8'h24);
    @(negedge clk);
    chk("R3", "upd_end one cycle", 8'(upd_end), 8'h00);
  endtask

  task automatic t_carries();
    load_time(8'h59, 8'h59, 8'h09, 8'h02, 8'h10, 8'h03, 8'h24);
    tick_full();
    expect_time("R6", 8'h00, 8'h00, 8'h10, 8'h02, 8'h10, 8'h03, 8'h24);
    load_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
    tick_full();
    expect_time("R8", 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
  endtask

  task automatic t_months();
    load_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h23);
    tick_full();
    expect_time("R7", 8'h00, 8'h00, 8'h00, 8'h03, 8'h01, 8'h03, 8'h23);
    load_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h24);
    tick_full();
    expect_time("R7", 8'h00, 8'h00, 8'h00, 8'h03, 8'h29, 8'h02, 8'h24);
    load_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h00);
    tick_full();
    expect_time("R7", 8'h00, 8'h00, 8'h00, 8'h03, 8'h29, 8'h02, 8'h00);
    load_time(8'h59, 8'h59, 8'h23, 8'h04, 8'h29, 8'h02, 8'h24);
    tick_full();
    expect_time("R7", 8'h00, 8'h00, 8'h00, 8'h05, 8'h01, 8'h03, 8'h24);
    load_time(8'h59, 8'h59, 8'h23, 8'h05, 8'h30, 8'h04, 8'h24);
    tick_full();
    expect_time("R7", 8'h00, 8'h00, 8'h00, 8'h06, 8'h01, 8'h05, 8'h24);
    load_time(8'h59, 8'h59, 8'h23, 8'h06, 8'h30, 8'h05, 8'h24);
    tick_full();
    expect_time("R7", 8'h00, 8'h00, 8'h00, 8'h07, 8'h31, 8'h05, 8'h24);
  endtask

  task automatic t_binary();
    bin_mode = 1'b1;
    load_time(8'd59, 8'd59, 8'd10, 8'd4, 8'd20, 8'd11, 8'd42);
    tick_full();
    expect_time("R4", 8'd0, 8'd0, 8'd11, 8'd4, 8'd20, 8'd11, 8'd42);
    bin_mode = 1'b0;
  endtask

  task automatic t_12h();
    hr24_mode = 1'b0;
    load_time(8'h59, 8'h59, 8'h11, 8'h01, 8'h05, 8'h07, 8'h24);
    tick_full();
    expect_time("R5", 8'h00, 8'h00, 8'h92, 8'h01, 8'h05, 8'h07, 8'h24);
    load_time(8'h59, 8'h59, 8'h92, 8'h01, 8'h05, 8'h07, 8'h24);
    tick_full();
    expect_time("R5", 8'h00, 8'h00, 8'h81, 8'h01, 8'h05, 8'h07, 8'h24);
    load_time(8'h59, 8'h59, 8'h91, 8'h01, 8'h05, 8'h07, 8'h24);
    tick_full();
    expect_time("R5", 8'h00, 8'h00, 8'h12, 8'h02, 8'h06, 8'h07, 8'h24);
    hr24_mode = 1'b1;
  endtask

  task automatic t_gate();
    load_time(8'h20, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    osc_ctl = 3'b000;
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
    chk("R1", "uip osc off", 8'(uip), 8'h00);
    repeat (WIN + 2) @(negedge clk);
    chk("R1", "sec osc off", t_sec, 8'h20);
    osc_ctl = 3'b011;
    tick_full();
    chk("R1", "sec osc 011", t_sec, 8'h20);
    osc_ctl = 3'b010;
    tick_full();
    chk("R1", "sec osc running", t_sec, 8'h21);
  endtask

  task automatic t_set();
    load_time(8'h40, 8'h10, 8'h05, 8'h01, 8'h01, 8'h01, 8'h00);
    @(negedge clk); set_mode = 1'b1;
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
    chk("R3", "uip in set mode", 8'(uip), 8'h00);
    repeat (WIN) @(negedge clk);
    chk("R3", "upd_end in set mode", 8'(upd_end), 8'h01);
    chk("R2", "sec frozen", t_sec, 8'h40);
    tick_full();
    chk("R2", "sec frozen 2", t_sec, 8'h40);
    @(negedge clk); set_mode = 1'b0;
    repeat (2) @(negedge clk);
    tick_full();
    chk("R2", "reload on set fall", t_sec, 8'h41);
  endtask

  task automatic t_host_write();
    write_byte(3'd0, 8'h30);
    @(negedge clk);
    chk("R2", "host write visible", t_sec, 8'h30);
    tick_full();
    chk("R2", "counter took host write", t_sec, 8'h31);
    write_byte(3'd7, 8'h55);
    @(negedge clk);
    expect_time("R10", 8'h31, 8'h10, 8'h05, 8'h01, 8'h01, 8'h01, 8'h00);
    tick_full();
    chk("R10", "sel 7 no effect on count", t_sec, 8'h32);
  endtask

  task automatic t_double_tick();
    load_time(8'h10, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
    repeat (2) @(negedge clk);
    sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
    repeat (WIN - 3) @(negedge clk);
    chk("R9", "one advance", t_sec, 8'h11);
    chk("R9", "window closed", 8'(uip), 8'h00);
    repeat (3) @(negedge clk);
    chk("R9", "no second window", 8'(uip), 8'h00);
    chk("R9", "sec stays", t_sec, 8'h11);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sec_tick = 1'b0; osc_ctl = 3'b010; set_mode = 1'b0;
    bin_mode = 1'b0; hr24_mode = 1'b1; ld_en = 1'b0; ld_sel = 3'd0; ld_data = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_carries();
    t_months();
    t_binary();
    t_12h();
    t_gate();
    t_set();
    t_host_write();
    t_double_tick();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule